// File: doc/BRIEF.md
# Shift and Rotate Execution Unit

This combinational unit executes the shift family of a 32-bit integer instruction set. It receives the six-bit function code and the four register/amount fields of an already decoded register-format instruction, together with the two source operand values. It returns the shifted word, a write-enable for the destination register, and a set of classification flags.

Six function codes are handled: three whose amount is the instruction's 5-bit amount field and three whose amount is taken from the low five bits of the first source operand. A right rotate has no function code of its own. Instead, one spare bit selects it inside each of the two logical right-shift encodings. The shift-left encoding with all register fields zero is a no-op. Two amount values within that no-op mark a superscalar no-op and an execution hazard barrier. The unit only flags these. Acting on them belongs to the pipeline around it.

Top module: `shr_unit`

## Requirements
- R1: Function 0x00 returns rt_val shifted left logically by shamt, with zeros filling the low bits.
- R2: Function 0x02 with rs_idx[0]=0 returns rt_val shifted right logically by shamt. With rs_idx[0]=1 it returns rt_val rotated right by shamt, equal to (rt_val >> n) | (rt_val << (32-n)).
- R3: Function 0x03 returns rt_val shifted right by shamt, and every vacated upper bit equals rt_val[31].
- R4: Functions 0x04 (left logical), 0x06 (right) and 0x07 (right arithmetic) take the amount from rs_val[4:0] only, and ignore rs_val[31:5]. For 0x06, shamt[0]=0 selects a logical shift and shamt[0]=1 selects a rotate.
- R5: An amount of 0 returns rt_val unchanged for every shift and rotate form.
- R6: is_nop is 1 exactly when funct=0x00 and rs_idx, rt_idx and rd_idx are all zero. is_ssnop is is_nop with shamt=1, and is_ehb is is_nop with shamt=3. All three flags are 0 otherwise.
- R7: rd_we is 1 exactly when the instruction is not reserved, not a no-op, and rd_idx is nonzero.
- R8: reserved is 1 in three cases: when funct is not one of 0x00, 0x02, 0x03, 0x04, 0x06 or 0x07; when funct is 0x00 or 0x03 and rs_idx is nonzero; and when funct is 0x02 and rs_idx[4:1] is nonzero. A reserved instruction gives result 0 and rd_we 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| funct | input | 6 | Function code of the instruction |
| rs_idx | input | 5 | First source register field |
| rt_idx | input | 5 | Second source register field |
| rd_idx | input | 5 | Destination register field |
| shamt | input | 5 | Immediate amount field |
| rs_val | input | 32 | First source operand value |
| rt_val | input | 32 | Second source operand value (data shifted) |
| result | output | 32 | Shifted or rotated word |
| rd_we | output | 1 | Destination write-enable |
| is_nop | output | 1 | No-op encoding detected |
| is_ssnop | output | 1 | Superscalar no-op encoding |
| is_ehb | output | 1 | Execution hazard barrier encoding |
| reserved | output | 1 | Reserved-instruction indication |

## Verification
The bench targets amount 0 and amount 31. A rotate built from two plain shifts would OR in a term shifted by 32 at amount 0, and a broken sign fill would clear bit 31 at amount 31. It sends negative and positive operands through both arithmetic forms. It places nonzero upper bits in rs_val, so a variable shift that used the whole operand would return the wrong word. It also walks the selector bit of both right-shift encodings and the rs_idx values that must make 0x02 reserved while leaving the rotate legal. Finally, it sweeps the no-op field combinations, where a decoder that ignored rt_idx or rd_idx would flag a real shift as a no-op and drop its write.

// File: rtl/shr_pkg.sv
package shr_pkg;
  localparam int unsigned XLEN = 32;
  localparam int unsigned AMTW = $clog2(XLEN);

  localparam logic [5:0] F_SLL  = 6'h00;
  localparam logic [5:0] F_SRL  = 6'h02;
  localparam logic [5:0] F_SRA  = 6'h03;
  localparam logic [5:0] F_SLLV = 6'h04;
  localparam logic [5:0] F_SRLV = 6'h06;
  localparam logic [5:0] F_SRAV = 6'h07;

  typedef enum logic [1:0] {
    SK_SLL = 2'd0,
    SK_SRL = 2'd1,
    SK_SRA = 2'd2,
    SK_ROR = 2'd3
  } shr_kind_e;

  // Low half of a double-width word {hi, lo} shifted right by amt.
  function automatic logic [XLEN-1:0] funnel_right(input logic [XLEN-1:0] hi,
                                                   input logic [XLEN-1:0] lo,
                                                   input logic [AMTW-1:0] amt);
    logic [2*XLEN-1:0] wide;
    wide = {hi, lo} >> amt;
    return wide[XLEN-1:0];
  endfunction
endpackage

// File: rtl/shr_decode.sv
module shr_decode
  import shr_pkg::*;
(
  input  logic [5:0]  funct,
  input  logic [4:0]  rs_idx,
  input  logic [4:0]  rt_idx,
  input  logic [4:0]  rd_idx,
  input  logic [4:0]  shamt,
  output shr_kind_e   kind,
  output logic        use_var_amt,
  output logic        rsv,
  output logic        nop,
  output logic        ssnop,
  output logic        ehb,
  output logic        wr_en
);
  always_comb begin
    kind        = SK_SLL;
    use_var_amt = 1'b0;
    rsv         = 1'b0;
    unique case (funct)
      F_SLL:  rsv = (rs_idx != 5'd0);
      F_SRL: begin
        kind = rs_idx[0] ? SK_ROR : SK_SRL;
        rsv  = (rs_idx[4:1] != 4'd0);
      end
      F_SRA: begin
        kind = SK_SRA;
        rsv  = (rs_idx != 5'd0);
      end
      F_SLLV: use_var_amt = 1'b1;
      F_SRLV: begin
        use_var_amt = 1'b1;
        kind        = shamt[0] ? SK_ROR : SK_SRL;
      end
      F_SRAV: begin
        use_var_amt = 1'b1;
        kind        = SK_SRA;
      end
      default: rsv = 1'b1;
    endcase
  end

  assign nop   = (funct == F_SLL) && (rs_idx == 5'd0) && (rt_idx == 5'd0) && (rd_idx == 5'd0);
  assign ssnop = nop && (shamt == 5'd1);
  assign ehb   = nop && (shamt == 5'd3);
  assign wr_en = !rsv && !nop && (rd_idx != 5'd0);

  always_comb begin
    AST_HINT_EXCL: assert ($onehot0({ssnop, ehb}) && (!(ssnop || ehb) || nop)) else $error("hint flags"); // R6
    AST_NOP_NO_WRITE: assert (!(nop && wr_en)) else $error("nop writes"); // R7
    AST_RD0_NO_WRITE: assert (!(rd_idx == 5'd0 && wr_en)) else $error("rd0 writes"); // R7
  end
endmodule

// File: rtl/shr_funnel.sv
module shr_funnel
  import shr_pkg::*;
#(
  parameter int unsigned W  = XLEN,
  parameter int unsigned AW = $clog2(W)
) (
  input  logic [W-1:0]  data,
  input  logic [AW-1:0] amt,
  input  shr_kind_e     kind,
  output logic [W-1:0]  out
);
  logic [W-1:0] data_rev, src, fill, raw, raw_rev;
  logic         left;

  // Left shifts reuse the right funnel on bit-reversed data.
  for (genvar i = 0; i < W; i++) begin : g_rev
    assign data_rev[i] = data[W-1-i];
    assign raw_rev[i]  = raw[W-1-i];
  end

  assign left = (kind == SK_SLL);
  assign src  = left ? data_rev : data;

  always_comb begin
    unique case (kind)
      SK_SRA:  fill = {W{data[W-1]}};
      SK_ROR:  fill = data;
      default: fill = '0;
    endcase
  end

  assign raw = funnel_right(fill, src, amt);
  assign out = left ? raw_rev : raw;

  always_comb begin
    AST_ZERO_AMT_PASS: assert (amt != '0 || out == data) else $error("amt0"); // R5
    AST_SRA_SIGN: assert (kind != SK_SRA || out[W-1] == data[W-1]) else $error("sra sign"); // R3
    AST_SLL_LSB: assert (kind != SK_SLL || amt == '0 || out[0] == 1'b0) else $error("sll lsb"); // R1
  end
endmodule

// File: rtl/shr_unit.sv
module shr_unit
  import shr_pkg::*;
(
  input  logic [5:0]  funct,
  input  logic [4:0]  rs_idx,
  input  logic [4:0]  rt_idx,
  input  logic [4:0]  rd_idx,
  input  logic [4:0]  shamt,
  input  logic [31:0] rs_val,
  input  logic [31:0] rt_val,
  output logic [31:0] result,
  output logic        rd_we,
  output logic        is_nop,
  output logic        is_ssnop,
  output logic        is_ehb,
  output logic        reserved
);
  shr_kind_e       kind;
  logic            use_var_amt;
  logic [AMTW-1:0] amt;
  logic [XLEN-1:0] shifted;

  shr_decode u_dec (
    .funct(funct), .rs_idx(rs_idx), .rt_idx(rt_idx), .rd_idx(rd_idx), .shamt(shamt),
    .kind(kind), .use_var_amt(use_var_amt), .rsv(reserved),
    .nop(is_nop), .ssnop(is_ssnop), .ehb(is_ehb), .wr_en(rd_we)
  );

  assign amt = use_var_amt ? rs_val[AMTW-1:0] : shamt;

  shr_funnel #(.W(XLEN), .AW(AMTW)) u_fun (
    .data(rt_val), .amt(amt), .kind(kind), .out(shifted)
  );

  assign result = reserved ? '0 : shifted;

  always_comb begin
    AST_RSV_QUIET: assert (!reserved || (result == '0 && !rd_we)) else $error("reserved"); // R8
  end
endmodule

// File: tb/shr_unit_tb.sv
module shr_unit_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic [5:0]  funct = '0;
  logic [4:0]  rs_idx = '0, rt_idx = '0, rd_idx = '0, shamt = '0;
  logic [31:0] rs_val = '0, rt_val = '0;
  logic [31:0] result;
  logic        rd_we, is_nop, is_ssnop, is_ehb, reserved;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 0;

  shr_unit u_dut (.*);

  // Behavioural reference, written from the requirements.
  function automatic logic [31:0] ror_ref(input logic [31:0] v, input int n);
    logic [31:0] r;
    for (int i = 0; i < 32; i++) r[i] = v[(i + n) % 32];
    return r;
  endfunction

  function automatic bit legal_f(input logic [5:0] f);
    return f inside {6'h00, 6'h02, 6'h03, 6'h04, 6'h06, 6'h07};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h (funct %h rs %0d rt %0d rd %0d sa %0d rsv %h rtv %h)",
               tag, act, exp, funct, rs_idx, rt_idx, rd_idx, shamt, rs_val, rt_val);
    end
  endtask

  always @(posedge clk) begin
    if (!rst && !done) begin
      automatic bit rsv_e, nop_e;
      automatic logic [31:0] res_e = 32'h0;
      automatic int n;
      automatic string tag = "R8";
      rsv_e = !legal_f(funct) || ((funct == 6'h00 || funct == 6'h03) && rs_idx != 0)
              || (funct == 6'h02 && rs_idx[4:1] != 0);
      nop_e = (funct == 6'h00) && rs_idx == 0 && rt_idx == 0 && rd_idx == 0;
      n = (funct >= 6'h04) ? int'(rs_val % 32) : int'(shamt);
      if (!rsv_e) begin
        case (funct)
          6'h00: begin res_e = rt_val << n; tag = "R1"; end
          6'h02: begin res_e = rs_idx[0] ? ror_ref(rt_val, n) : rt_val >> n; tag = "R2"; end
          6'h03: begin res_e = $unsigned($signed(rt_val) >>> n); tag = "R3"; end
          6'h04: begin res_e = rt_val << n; tag = "R4"; end
          6'h06: begin res_e = shamt[0] ? ror_ref(rt_val, n) : rt_val >> n; tag = "R4"; end
          default: begin res_e = $unsigned($signed(rt_val) >>> n); tag = "R4"; end
        endcase
        if (n == 0) tag = "R5";
      end
      chk(tag, result, res_e);
      chk("R8 reserved", {31'b0, reserved}, {31'b0, rsv_e});
      chk("R7 rd_we", {31'b0, rd_we}, {31'b0, !rsv_e && !nop_e && rd_idx != 0});
      chk("R6 flags", {29'b0, is_nop, is_ssnop, is_ehb},
          {29'b0, nop_e, nop_e && shamt == 1, nop_e && shamt == 3});
    end
  end

  task automatic drive(input logic [5:0] f, input logic [4:0] s, input logic [4:0] t,
                       input logic [4:0] d, input logic [4:0] a,
                       input logic [31:0] sv, input logic [31:0] tv);
    @(negedge clk);
    funct = f; rs_idx = s; rt_idx = t; rd_idx = d; shamt = a; rs_val = sv; rt_val = tv;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;                                         // all-zero inputs: plain no-op
    drive(6'h00, 0, 0, 0, 1, 0, 0);                     // R6 ssnop
    drive(6'h00, 0, 0, 0, 3, 0, 0);                     // R6 ehb
    drive(6'h00, 0, 0, 0, 2, 0, 0);                     // R6 nop only
    drive(6'h00, 0, 1, 0, 3, 0, 32'h1);                 // R6 rt nonzero: not a no-op
    drive(6'h00, 0, 0, 4, 1, 0, 32'h0);                 // R6/R7 rd nonzero
    drive(6'h00, 0, 2, 3, 31, 0, 32'hFFFF_FFFF);        // R1
    drive(6'h00, 1, 2, 3, 4, 0, 32'h1);                 // R8 rs on sll
    drive(6'h02, 0, 2, 3, 0, 0, 32'hDEAD_BEEF);         // R5 srl 0
    drive(6'h02, 1, 2, 3, 0, 0, 32'hDEAD_BEEF);         // R5 rotate 0
    drive(6'h02, 1, 2, 3, 8, 0, 32'h1234_5678);         // R2 rotate
    drive(6'h02, 1, 2, 3, 31, 0, 32'h8000_0001);        // R2 rotate 31
    drive(6'h02, 3, 2, 3, 8, 0, 32'h1234_5678);         // R8 rs[4:1]
    drive(6'h03, 0, 2, 3, 31, 0, 32'h8000_0000);        // R3 full fill
    drive(6'h03, 0, 2, 3, 31, 0, 32'h7FFF_FFFF);        // R3 positive
    drive(6'h03, 2, 2, 3, 1, 0, 32'h8000_0000);         // R8 rs on sra
    drive(6'h04, 7, 2, 3, 9, 32'hFFFF_FFE3, 32'h1);     // R4 upper bits ignored
    drive(6'h06, 7, 2, 3, 1, 32'hABCD_0020, 32'hCAFE_F00D); // R4/R5 rotate by 0
    drive(6'h06, 7, 2, 3, 1, 32'h0000_0004, 32'hCAFE_F00D); // R4 rotate
    drive(6'h06, 7, 2, 3, 0, 32'h0000_0004, 32'hCAFE_F00D); // R4 srl
    drive(6'h07, 7, 2, 3, 0, 32'h0000_001F, 32'h9000_0000); // R4 srav
    drive(6'h07, 7, 2, 0, 0, 32'h0000_0001, 32'h9000_0000); // R7 rd zero
    drive(6'h01, 0, 2, 3, 0, 0, 32'h1);                 // R8 illegal funct
    drive(6'h05, 0, 2, 3, 0, 0, 32'h1);                 // R8 illegal funct
    for (int k = 0; k < 3000; k++) begin
      automatic logic [5:0] fl[8] = '{6'h00, 6'h02, 6'h03, 6'h04, 6'h06, 6'h07, 6'h01, 6'h00};
      automatic logic [5:0] f = ($urandom % 8 == 0) ? 6'($urandom) : fl[$urandom % 8];
      automatic logic [4:0] s = ($urandom % 2) ? 5'($urandom % 2) : 5'($urandom);
      automatic logic [4:0] t = ($urandom % 3 == 0) ? 5'd0 : 5'($urandom);
      automatic logic [4:0] d = ($urandom % 3 == 0) ? 5'd0 : 5'($urandom);
      drive(f, s, t, d, 5'($urandom), $urandom, $urandom);
    end
    @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000 && !done) begin
        done = 1;
        checks++;
        fails++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
      end
    end
  end
endmodule